// File: doc/BRIEF.md
# Dual-Protocol Register Write Port

This block is the slave end of a serial control port. It receives register writes over a two-wire bus with open-drain data, or over a four-wire SPI-style link. It then presents each received data byte on the core side as a register write, carrying a 4-bit register index and an 8-bit value. The port never acts as bus master. All serial pins are oversampled in the core clock domain through two-flop synchronizers, so the serial clock must stay well below the core clock. Each serial half-period must last at least four core cycles.

Both protocols share one pin, `cs_ad_i`. After reset the port runs in two-wire mode, and the level on `cs_ad_i` acts as the least significant bit of the slave address. The first high-to-low transition on that pin moves the port into SPI mode, where the pin becomes an active-low chip select. The port stays in SPI mode until the next reset.

A transfer has the same layout in both modes. First comes an address byte: seven address bits followed by a read/write flag. Next comes a pointer byte whose low nibble selects the register. One or more data bytes follow. The core-side write interface is valid/ready. A write stays presented until the core accepts it. The serial side cannot be stalled, so a data byte that completes while an earlier write is still waiting is dropped. The pointer advances past that byte anyway. The core must therefore accept each write within about one serial byte time to lose nothing.

Top module: `ctrl_port_slave`

## Requirements
- R1: After reset, `wr_valid` is 0, `sda_oe` is 0, and the port is in two-wire mode.
- R2: In two-wire mode a transfer opens with a start condition (data falls while clock is high). Address byte bits [7:2] must equal `DEV_ADDR_HI`, bit 1 must equal the level on `cs_ad_i`, and bit 0 (the read/write flag) must be 0. On a match the port drives `sda_oe` high through the ninth clock. On any mismatch, or with the flag set, it gives no acknowledge and ignores the bus until the next start condition.
- R3: In the pointer byte, bits [3:0] load the register pointer and bits [7:4] are ignored. Each data byte produces a write to the current pointer, after which the pointer advances by one modulo 16. In two-wire mode, pointer and data bytes are acknowledged.
- R4: The first falling edge on `cs_ad_i` after reset selects SPI mode, which persists until reset. In SPI mode, two-wire traffic produces no writes and `sda_oe` stays 0.
- R5: In SPI mode a frame lasts while `cs_ad_i` is low. Bits arrive MSB first on `sda_i` and are sampled on rising edges of `scl_i`. The first byte must equal {`DEV_ADDR_HI`, 0, 0}. Otherwise the rest of the frame is ignored.
- R6: A start condition in the middle of a byte discards the partial byte and begins a new transfer.
- R7: In SPI mode, a rise of `cs_ad_i` in the middle of a byte discards the partial byte.
- R8: Once `wr_valid` is high, it stays high with `wr_addr` and `wr_data` stable until a cycle with `wr_ready` high. A data byte that completes while a write is still pending is discarded.
- R9: A stop condition (data rises while clock is high) ends the transfer, and nothing more is written until the next start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock (two-wire clock or SPI clock) |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | When 1, the pad pulls the data line low (acknowledge) |
| cs_ad_i | input | 1 | Address low bit in two-wire mode; active-low chip select in SPI mode |
| wr_valid | output | 1 | A register write is presented |
| wr_ready | input | 1 | Core accepts the presented write |
| wr_addr | output | MAP_W | Register index of the write |
| wr_data | output | 8 | Value to write |

## Verification
On every cycle, assertions check that the SPI selection never reverts and is entered only from a chip-select fall. They also check that the acknowledge drive only switches on while the serial clock is low and is never active in SPI mode, that the pointer steps by one after each data byte, and that a pending write holds still under back-pressure. The directed scenarios show what only whole transfers can: address matching against the pin level and the read flag, pointer wrap across sixteen registers, abort of partial bytes by a restart or a chip-select rise, dropping of bytes under back-pressure, and the return to two-wire mode after reset.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_MAP,
    PH_DATA,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    ACK_NONE,
    ACK_WAIT,
    ACK_DRIVE
  } ack_t;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta, stage, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= '0;
      stage <= '0;
      prev  <= '0;
    end else begin
      meta  <= din;
      stage <= meta;
      prev  <= stage;
    end
  end

  assign lvl  = stage;
  assign rise = stage & ~prev;
  assign fall = ~stage & prev;
endmodule

// File: rtl/cps_mode_sel.sv
module cps_mode_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_fall,
  output logic spi_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       spi_mode <= 1'b0;
    else if (cs_fall) spi_mode <= 1'b1;
  end

  p_spi_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode);
  p_spi_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_mode) |-> $past(cs_fall));
endmodule

// File: rtl/cps_frame.sv
module cps_frame
  import cps_pkg::*;
#(
  parameter logic [5:0] DEV_HI = 6'b100101,
  parameter int         MAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi,
  input  logic              spi_now,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic              cs_lvl,
  input  logic              cs_rise,
  input  logic              cs_fall,
  output logic              sda_drive,
  output logic              dbyte_stb,
  output logic [BYTE_W-1:0] dbyte,
  output logic [MAP_W-1:0]  dptr
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              active;
  phase_t            ph;
  ack_t              ack;
  logic [CNT_W-1:0]  bcnt;
  logic [BYTE_W-1:0] sh;
  logic [MAP_W-1:0]  ptr;

  logic tw_start, tw_stop, sp_start, sp_end, sample, last_bit, addr_ok;
  logic [BYTE_W-1:0] sh_nx;

  assign tw_start = !spi_now && scl_lvl && sda_fall;
  assign tw_stop  = !spi_now && scl_lvl && sda_rise;
  assign sp_start = spi_now && cs_fall;
  assign sp_end   = spi && cs_rise;
  assign sample   = active && scl_rise && (spi ? !cs_lvl : (ack == ACK_NONE));
  assign last_bit = (bcnt == CNT_W'(BYTE_W - 1));
  assign sh_nx    = {sh[BYTE_W-2:0], sda_lvl};
  assign addr_ok  = (sh_nx[7:2] == DEV_HI) && (sh_nx[1] == (spi ? 1'b0 : cs_lvl)) && !sh_nx[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      ph        <= PH_ADDR;
      ack       <= ACK_NONE;
      bcnt      <= '0;
      sh        <= '0;
      ptr       <= '0;
      dbyte_stb <= 1'b0;
      dbyte     <= '0;
    end else begin
      dbyte_stb <= 1'b0;
      if (tw_start || sp_start) begin
        active <= 1'b1;
        ph     <= PH_ADDR;
        ack    <= ACK_NONE;
        bcnt   <= '0;
      end else if (tw_stop || sp_end) begin
        active <= 1'b0;
        ack    <= ACK_NONE;
        bcnt   <= '0;
      end else begin
        if (!spi && scl_fall) begin
          if (ack == ACK_WAIT)       ack <= ACK_DRIVE;
          else if (ack == ACK_DRIVE) ack <= ACK_NONE;
        end
        if (sample) begin
          sh   <= sh_nx;
          bcnt <= bcnt + 1'b1;
          if (last_bit) begin
            unique case (ph)
              PH_ADDR: begin
                if (addr_ok) begin
                  ph  <= PH_MAP;
                  ack <= spi ? ACK_NONE : ACK_WAIT;
                end else begin
                  ph  <= PH_SKIP;
                end
              end
              PH_MAP: begin
                ptr <= sh_nx[MAP_W-1:0];
                ph  <= PH_DATA;
                ack <= spi ? ACK_NONE : ACK_WAIT;
              end
              PH_DATA: begin
                dbyte_stb <= 1'b1;
                dbyte     <= sh_nx;
                ptr       <= ptr + 1'b1;
                ack       <= spi ? ACK_NONE : ACK_WAIT;
              end
              default: ph <= PH_SKIP;
            endcase
          end
        end
      end
    end
  end

  // Data-byte strobe carries the pointer value before its increment.
  logic [MAP_W-1:0] ptr_at_stb;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ptr_at_stb <= '0;
    else if (sample && last_bit && ph == PH_DATA) ptr_at_stb <= ptr;
  end

  assign dptr      = ptr_at_stb;
  assign sda_drive = (ack == ACK_DRIVE);

  p_ack_on_low_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive) |-> !scl_lvl);
  p_no_ack_in_spi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi |-> !sda_drive);
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dbyte_stb |-> ptr == dptr + 1'b1);
endmodule

// File: rtl/cps_wr_port.sv
module cps_wr_port
  import cps_pkg::*;
#(
  parameter int MAP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [MAP_W-1:0]  addr,
  input  logic [BYTE_W-1:0] data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [MAP_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (stb && !wr_valid) begin
      wr_valid <= 1'b1;
      wr_addr  <= addr;
      wr_data  <= data;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  p_hold_under_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/ctrl_port_slave.sv
module ctrl_port_slave
  import cps_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b100101,
  parameter int         MAP_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              cs_ad_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [MAP_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int NPIN = 3;
  localparam int I_SCL = 0, I_SDA = 1, I_CS = 2;

  logic [NPIN-1:0] lvl, rise, fall;
  logic spi_mode, dbyte_stb;
  logic [BYTE_W-1:0] dbyte;
  logic [MAP_W-1:0] dptr;

  cps_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_ad_i, sda_i, scl_i}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  cps_mode_sel u_mode (
    .clk(clk), .rst_n(rst_n), .cs_fall(fall[I_CS]), .spi_mode(spi_mode)
  );

  cps_frame #(.DEV_HI(DEV_ADDR_HI), .MAP_W(MAP_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .spi(spi_mode), .spi_now(spi_mode | fall[I_CS]),
    .scl_lvl(lvl[I_SCL]), .scl_rise(rise[I_SCL]), .scl_fall(fall[I_SCL]),
    .sda_lvl(lvl[I_SDA]), .sda_rise(rise[I_SDA]), .sda_fall(fall[I_SDA]),
    .cs_lvl(lvl[I_CS]), .cs_rise(rise[I_CS]), .cs_fall(fall[I_CS]),
    .sda_drive(sda_oe), .dbyte_stb(dbyte_stb), .dbyte(dbyte), .dptr(dptr)
  );

  cps_wr_port #(.MAP_W(MAP_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .stb(dbyte_stb), .addr(dptr), .data(dbyte),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: tb/ctrl_port_slave_test.sv
`timescale 1ns/1ps
module ctrl_port_slave_test;
  localparam int HP = 8;
  localparam logic [7:0] A_W0 = 8'h94;  // addr, pin bit 0, write
  localparam logic [7:0] A_W1 = 8'h96;  // addr, pin bit 1, write
  localparam logic [7:0] A_RD = 8'h95;  // read flag set

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1, cs = 0, wr_ready = 1;
  logic sda_oe, wr_valid;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  wire sda_w = sda_m & ~sda_oe;

  int vectors = 0, fails = 0, n_log = 0;
  logic [3:0] log_a [0:63];
  logic [7:0] log_d [0:63];
  bit done = 0;

  always #2.5 clk = ~clk;

  ctrl_port_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_w), .sda_oe(sda_oe),
    .cs_ad_i(cs), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) if (rst_n && wr_valid && wr_ready) begin
    log_a[n_log[5:0]] <= wr_addr;
    log_d[n_log[5:0]] <= wr_data;
    n_log <= n_log + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic tw_start();
    sda_m = 1; w(HP); scl = 1; w(HP); sda_m = 0; w(HP); scl = 0; w(HP);
  endtask
  task automatic tw_stop();
    sda_m = 0; w(HP); scl = 1; w(HP); sda_m = 1; w(HP);
  endtask
  task automatic clk_bit(input logic b);
    sda_m = b; w(HP); scl = 1; w(HP); scl = 0; w(HP);
  endtask
  task automatic tw_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) clk_bit(v[i]);
    sda_m = 1; w(HP); scl = 1; w(HP/2); ack = sda_oe; w(HP/2); scl = 0; w(HP);
  endtask
  task automatic spi_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic t_reset();
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_single();
    logic a; int b = n_log;
    tw_start(); tw_byte(A_W0, a); chk("R2 addr ack", a, 1);
    tw_byte(8'h05, a); chk("R3 ptr ack", a, 1);
    tw_byte(8'hA5, a); chk("R3 data ack", a, 1);
    tw_stop(); w(20);
    chk("R3 single count", n_log - b, 1);
    chk("R3 single addr", log_a[b], 5);
    chk("R3 single data", log_d[b], 8'hA5);
  endtask

  task automatic t_burst_wrap();
    logic a; int b = n_log;
    tw_start(); tw_byte(A_W0, a); tw_byte(8'h3E, a);
    tw_byte(8'h11, a); tw_byte(8'h22, a); tw_byte(8'h33, a); tw_stop(); w(20);
    chk("R3 burst count", n_log - b, 3);
    chk("R3 burst a0", log_a[b], 4'hE);
    chk("R3 burst a1", log_a[b+1], 4'hF);
    chk("R3 wrap a2", log_a[b+2], 4'h0);
    chk("R3 burst d2", log_d[b+2], 8'h33);
  endtask

  task automatic t_read_flag();
    logic a; int b = n_log;
    tw_start(); tw_byte(A_RD, a); chk("R2 read nack", a, 0);
    tw_byte(8'h02, a); chk("R2 ignored nack", a, 0);
    tw_byte(8'h44, a); tw_stop(); w(20);
    chk("R2 read no write", n_log - b, 0);
  endtask

  task automatic t_restart_abort();
    logic a; int b = n_log;
    tw_start(); tw_byte(A_W0, a); tw_byte(8'h07, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b1);
    tw_start(); tw_byte(A_W0, a); tw_byte(8'h01, a); tw_byte(8'h5C, a); tw_stop(); w(20);
    chk("R6 abort count", n_log - b, 1);
    chk("R6 abort addr", log_a[b], 1);
    chk("R6 abort data", log_d[b], 8'h5C);
  endtask

  task automatic t_after_stop();
    logic a; int b = n_log;
    tw_start(); tw_byte(A_W0, a); tw_byte(8'h04, a); tw_stop();
    scl = 0; w(HP); tw_byte(8'h66, a); chk("R9 no ack after stop", a, 0);
    scl = 1; w(HP); w(20);
    chk("R9 no write after stop", n_log - b, 0);
  endtask

  task automatic t_backpressure();
    logic a; int b = n_log;
    wr_ready = 0;
    tw_start(); tw_byte(A_W0, a); tw_byte(8'h03, a);
    tw_byte(8'h10, a); tw_byte(8'h20, a); tw_stop(); w(20);
    chk("R8 held valid", wr_valid, 1);
    chk("R8 held addr", wr_addr, 3);
    chk("R8 held data", wr_data, 8'h10);
    wr_ready = 1; w(5);
    chk("R8 dropped second", n_log - b, 1);
    chk("R8 valid clears", wr_valid, 0);
  endtask

  task automatic t_pin_addr();
    logic a; int b = n_log;
    cs = 1; w(HP);
    tw_start(); tw_byte(A_W0, a); chk("R2 pin mismatch nack", a, 0); tw_stop();
    tw_start(); tw_byte(A_W1, a); chk("R2 pin match ack", a, 1);
    tw_byte(8'h0A, a); tw_byte(8'hC3, a); tw_stop(); w(20);
    chk("R2 pin count", n_log - b, 1);
    chk("R2 pin data", log_d[b], 8'hC3);
  endtask

  task automatic t_spi();
    int b = n_log;
    scl = 0; w(HP); cs = 0; w(HP);
    spi_byte(A_W0); spi_byte(8'h02); spi_byte(8'h11); spi_byte(8'h22);
    cs = 1; w(20);
    chk("R5 spi count", n_log - b, 2);
    chk("R5 spi a0", log_a[b], 2);
    chk("R5 spi d1", log_d[b+1], 8'h22);
    chk("R4 spi no oe", sda_oe, 0);
  endtask

  task automatic t_spi_abort();
    int b = n_log;
    cs = 0; w(HP); spi_byte(A_W0); spi_byte(8'h08);
    for (int i = 0; i < 5; i++) clk_bit(1'b0);
    cs = 1; w(20);
    chk("R7 partial dropped", n_log - b, 0);
    cs = 0; w(HP); spi_byte(A_W0); spi_byte(8'h09); spi_byte(8'h77); cs = 1; w(20);
    chk("R7 next frame count", n_log - b, 1);
    chk("R7 next frame addr", log_a[b], 9);
  endtask

  task automatic t_spi_badaddr();
    int b = n_log;
    cs = 0; w(HP); spi_byte(A_W1); spi_byte(8'h01); spi_byte(8'h99); cs = 1; w(20);
    chk("R5 bad addr", n_log - b, 0);
  endtask

  task automatic t_sticky();
    logic a; int b = n_log; int oe_seen = 0;
    scl = 1; sda_m = 1; w(HP);
    tw_start(); tw_byte(A_W1, a); if (a) oe_seen = 1;
    tw_byte(8'h01, a); if (a) oe_seen = 1;
    tw_byte(8'h55, a); if (a) oe_seen = 1;
    tw_stop(); w(20);
    chk("R4 sticky no write", n_log - b, 0);
    chk("R4 sticky no ack", oe_seen, 0);
  endtask

  task automatic t_rereset();
    logic a; int b;
    rst_n = 0; cs = 0; scl = 1; sda_m = 1; w(5);
    t_reset();
    rst_n = 1; w(10); b = n_log;
    tw_start(); tw_byte(A_W0, a); chk("R4 two-wire after reset", a, 1);
    tw_byte(8'h06, a); tw_byte(8'hE7, a); tw_stop(); w(20);
    chk("R4 reset write count", n_log - b, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    w(5); t_reset(); rst_n = 1; w(10);
    t_reset();
    t_single();
    t_burst_wrap();
    t_read_flag();
    t_restart_abort();
    t_after_stop();
    t_backpressure();
    t_pin_addr();
    t_spi();
    t_spi_abort();
    t_spi_badaddr();
    t_sticky();
    t_rereset();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule